// File: doc/BRIEF.md
# Transfer Verify and Read Arbiter

This block sits between a controller and a simple single-port memory and checks each word it moves. When a word is written, the block writes it and then reads the same location back. It XORs the read-back word with the value it sent, so every set bit in the result marks a bit position that came back wrong. The block reports that bit mask together with the address of the transfer.

For transfers out of memory, the block reads the location twice. If the two readings agree, that value is the result. If they differ, the block keeps both readings and issues a third read. The reading that the third one matches wins. If no two of the three agree, the block raises an unresolved flag.

Only the write mode can expose a persistent fault in the path. The read mode only guards against transient read errors. A saturating counter totals the verifies that found an error, and a clear input resets it.

Top module: `xv_top`

## Requirements
- R1: After reset, done, error, unresolved, error mask, error count and the memory enable are all zero.
- R2: A request with mode 0 (write verify) writes the word, then reads the same address back. The memory returns read data one cycle after the read is issued. Done rises in the 4th cycle after the cycle in which the request is accepted. The value output shows the read-back word.
- R3: In write verify, the error mask equals the read-back word XOR the word sent. The error flag is set exactly when the mask is nonzero. The address output shows the request address.
- R4: A request with mode 1 (read verify) issues two reads of the address. If the two readings are equal, done rises in the 4th cycle after acceptance with that value, error 0 and mask 0, and no third read is issued.
- R5: In read verify, when the two readings differ, a third read is issued and done rises in the 6th cycle after acceptance. The error flag is 1, the mask is the first reading XOR the second, and the value is whichever earlier reading equals the third.
- R6: If the third reading matches neither earlier reading, unresolved is 1, the error flag is 1, and the value is the second reading.
- R7: Done is high for exactly one cycle. Error, unresolved, mask, address and value hold their values until the next done.
- R8: A request raised while a verify is in progress is ignored. It causes no memory access and no extra done.
- R9: The error count rises by one for each done that carries an error, and it stays at 255 once it reaches 255.
- R10: The clear input sets the error count to zero on the next clock edge. Clear takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start a verify (taken only when idle) |
| req_mode_i | input | 1 | 0 = write verify, 1 = read verify |
| req_addr_i | input | 12 | Word address |
| req_data_i | input | 16 | Word to write (write verify) |
| clr_cnt_i | input | 1 | Clear the error count |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 12 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after a read |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last verify found an error |
| unresolved_o | output | 1 | Last read verify had three different readings |
| err_mask_o | output | 16 | Bit positions found wrong |
| err_addr_o | output | 12 | Address of the last verify |
| value_o | output | 16 | Read-back or arbitrated word |
| err_cnt_o | output | 8 | Saturating count of verifies with an error |

## Verification
A sequencer stuck in or skipping a state would show up at the ports within one transfer. Done would arrive at the wrong cycle count, or the number of memory reads and writes per request would change, and both are counted against the fixed 4- and 6-cycle latencies. A wrong captured reading shows directly in the value or mask at the done of that same request. Counter faults appear only across many verifies, so the counter is driven past 255 and cleared while an increment is due.

// File: rtl/xv_pkg.sv
// Shared types for the transfer verifier.
// Assumes: one verify in flight at a time.
package xv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_WR,
        ST_W_RD,
        ST_W_CHK,
        ST_R_RD1,
        ST_R_RD2,
        ST_R_CMP,
        ST_R_RD3,
        ST_R_VOTE
    } xv_state_t;

    typedef enum logic {
        MODE_WRITE = 1'b0,
        MODE_READ  = 1'b1
    } xv_mode_t;

endpackage

// File: rtl/xv_seq.sv
// Sequencer: walks one verify through its memory accesses.
// Assumes: memory read data arrives exactly one cycle after a read strobe,
// and writes complete in the cycle they are strobed.
module xv_seq
    import xv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_i,
    input  logic      mode_i,
    input  logic      disagree_i,
    output xv_state_t state_o,
    output logic      accept_o,
    output logic      mem_en_o,
    output logic      mem_we_o,
    output logic      cap_first_o,
    output logic      cap_second_o,
    output logic      finish_o
);

    xv_state_t state, nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state choice
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_i) nxt = (mode_i == MODE_READ) ? ST_R_RD1 : ST_W_WR;
            ST_W_WR:   nxt = ST_W_RD;
            ST_W_RD:   nxt = ST_W_CHK;
            ST_W_CHK:  nxt = ST_IDLE;
            ST_R_RD1:  nxt = ST_R_RD2;
            ST_R_RD2:  nxt = ST_R_CMP;
            ST_R_CMP:  nxt = disagree_i ? ST_R_RD3 : ST_IDLE;
            ST_R_RD3:  nxt = ST_R_VOTE;
            ST_R_VOTE: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // memory strobes and datapath controls decoded from state
    always_comb begin
        accept_o     = (state == ST_IDLE) && req_i;
        mem_en_o     = (state == ST_W_WR) || (state == ST_W_RD) ||
                       (state == ST_R_RD1) || (state == ST_R_RD2) ||
                       (state == ST_R_RD3);
        mem_we_o     = (state == ST_W_WR);
        cap_first_o  = (state == ST_R_RD2);
        cap_second_o = (state == ST_R_CMP);
        finish_o     = (state == ST_W_CHK) || (state == ST_R_VOTE) ||
                       ((state == ST_R_CMP) && !disagree_i);
    end

    assign state_o = state;

    // R2
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (mem_en_o && !mem_we_o));

    // R5
    third_rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_R_RD3) |-> $past(disagree_i));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && req_i) |=> (state != ST_W_WR && state != ST_R_RD1));

endmodule

// File: rtl/xv_judge.sv
// Judge: compares readings and picks the result for the current state.
// Assumes: first/second readings are already captured when the vote runs.
module xv_judge
    import xv_pkg::*;
#(
    parameter int DATA_W = 16
)(
    input  xv_state_t         state_i,
    input  logic [DATA_W-1:0] expect_i,
    input  logic [DATA_W-1:0] first_i,
    input  logic [DATA_W-1:0] second_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              disagree_o,
    output logic              err_o,
    output logic              unres_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] value_o
);

    // per-state comparison and selection
    always_comb begin
        disagree_o = 1'b0;
        err_o      = 1'b0;
        unres_o    = 1'b0;
        mask_o     = '0;
        value_o    = rdata_i;
        unique case (state_i)
            ST_W_CHK: begin
                mask_o  = rdata_i ^ expect_i;
                err_o   = |mask_o;
                value_o = rdata_i;
            end
            ST_R_CMP: begin
                disagree_o = (first_i != rdata_i);
                value_o    = first_i;
            end
            ST_R_VOTE: begin
                mask_o = first_i ^ second_i;
                err_o  = |mask_o;
                if (rdata_i == second_i) begin
                    value_o = second_i;
                end else if (rdata_i == first_i) begin
                    value_o = first_i;
                end else begin
                    value_o = second_i;
                    unres_o = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xv_errcnt.sv
// Error counter: saturating count of failed verifies, with clear.
// Assumes: clear wins over a same-cycle increment.
module xv_errcnt #(
    parameter int CNT_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // count update
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_o <= '0;
        else if (clr_i)                     cnt_o <= '0;
        else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && !clr_i) |=> (cnt_o == CNT_MAX));

    // R10
    cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/xv_top.sv
// Transfer verifier top: write read-back check and three-read arbitration.
// Assumes: a single memory port with one-cycle read latency; results are
// held from one done pulse until the next.
module xv_top #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_mode_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_data_i,
    input  logic              clr_cnt_i,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic              err_o,
    output logic              unresolved_o,
    output logic [DATA_W-1:0] err_mask_o,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic [DATA_W-1:0] value_o,
    output logic [CNT_W-1:0]  err_cnt_o
);
    import xv_pkg::*;

    xv_state_t         st;
    logic              accept, cap_first, cap_second, finish, disagree;
    logic              j_err, j_unres;
    logic [DATA_W-1:0] j_mask, j_value;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q, first_q, second_q;

    xv_seq i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .mode_i       (req_mode_i),
        .disagree_i   (disagree),
        .state_o      (st),
        .accept_o     (accept),
        .mem_en_o     (mem_en_o),
        .mem_we_o     (mem_we_o),
        .cap_first_o  (cap_first),
        .cap_second_o (cap_second),
        .finish_o     (finish)
    );

    xv_judge #(.DATA_W(DATA_W)) i_judge (
        .state_i    (st),
        .expect_i   (data_q),
        .first_i    (first_q),
        .second_i   (second_q),
        .rdata_i    (mem_rdata_i),
        .disagree_o (disagree),
        .err_o      (j_err),
        .unres_o    (j_unres),
        .mask_o     (j_mask),
        .value_o    (j_value)
    );

    xv_errcnt #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_cnt_i),
        .inc_i (finish && j_err),
        .cnt_o (err_cnt_o)
    );

    // latch request fields on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr_i;
            data_q <= req_data_i;
        end
    end

    // capture the first and second readings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= '0;
            second_q <= '0;
        end else begin
            if (cap_first)  first_q  <= mem_rdata_i;
            if (cap_second) second_q <= mem_rdata_i;
        end
    end

    // register results and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o       <= 1'b0;
            err_o        <= 1'b0;
            unresolved_o <= 1'b0;
            err_mask_o   <= '0;
            err_addr_o   <= '0;
            value_o      <= '0;
        end else begin
            done_o <= finish;
            if (finish) begin
                err_o        <= j_err;
                unresolved_o <= j_unres;
                err_mask_o   <= j_mask;
                err_addr_o   <= addr_q;
                value_o      <= j_value;
            end
        end
    end

    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = data_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(err_mask_o) && $stable(value_o) && $stable(err_addr_o)));

    // R6
    unres_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unresolved_o |-> err_o);

    // R3
    mask_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (err_o == (err_mask_o != '0)));

endmodule

// File: tb/test_xv_top.sv
module test_xv_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_mode = 1'b0, clr = 1'b0;
    logic [11:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic        mem_en, mem_we;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        done, err, unres;
    logic [15:0] mask, value;
    logic [11:0] eaddr;
    logic [7:0]  ecnt;

    int n_chk = 0, n_fail = 0;
    int exp_cnt = 0;

    // bench memory model with fault injection
    logic [15:0] mem [64];
    logic [15:0] wr_flip = '0;
    logic [15:0] rd_flip [3];
    int          rd_total = 0, wr_total = 0, rd_seen = 0;

    xv_top i_xv_top (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_mode_i(req_mode),
        .req_addr_i(req_addr), .req_data_i(req_data), .clr_cnt_i(clr),
        .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .done_o(done), .err_o(err), .unresolved_o(unres),
        .err_mask_o(mask), .err_addr_o(eaddr), .value_o(value),
        .err_cnt_o(ecnt)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (mem_en && mem_we) begin
            mem[mem_addr[5:0]] <= mem_wdata ^ wr_flip;
            wr_total <= wr_total + 1;
        end else if (mem_en) begin
            mem_rdata <= mem[mem_addr[5:0]] ^ rd_flip[(rd_total - rd_seen) < 3 ? (rd_total - rd_seen) : 2];
            rd_total  <= rd_total + 1;
        end
    end

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic check(input string req_tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
        end
    endtask

    // issue one request and wait for done; returns latency and access counts
    task automatic run(input logic m, input logic [11:0] a, input logic [15:0] d,
                       output int lat, output int nrd, output int nwr);
        int rd0, wr0;
        @(negedge clk);
        rd_seen = rd_total;
        rd0 = rd_total; wr0 = wr_total;
        req = 1'b1; req_mode = m; req_addr = a; req_data = d;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        nrd = rd_total - rd0;
        nwr = wr_total - wr0;
    endtask

    task automatic t_reset();
        check("R1 done", done, 0);
        check("R1 err", err, 0);
        check("R1 unres", unres, 0);
        check("R1 mask", mask, 0);
        check("R1 cnt", ecnt, 0);
        check("R1 mem_en", mem_en, 0);
    endtask

    task automatic t_write_clean();
        int lat, nrd, nwr;
        wr_flip = 16'h0000;
        run(1'b0, 12'h005, 16'hA5C3, lat, nrd, nwr);
        check("R2 latency", lat, 4);
        check("R2 writes", nwr, 1);
        check("R2 reads", nrd, 1);
        check("R2 value", value, 16'hA5C3);
        check("R3 err clean", err, 0);
        check("R3 mask clean", mask, 0);
        check("R3 addr", eaddr, 12'h005);
    endtask

    task automatic t_write_fault();
        int lat, nrd, nwr;
        wr_flip = 16'h0104;
        run(1'b0, 12'h00A, 16'h3C3C, lat, nrd, nwr);
        wr_flip = 16'h0000;
        exp_cnt++;
        check("R3 err", err, 1);
        check("R3 mask", mask, 16'h0104);
        check("R3 addr", eaddr, 12'h00A);
        check("R2 value", value, 16'h3C3C ^ 16'h0104);
        check("R9 count", ecnt, exp_cnt);
    endtask

    task automatic t_read_equal();
        int lat, nrd, nwr;
        run(1'b0, 12'h009, 16'h1234, lat, nrd, nwr);
        run(1'b1, 12'h009, 16'h0000, lat, nrd, nwr);
        check("R4 latency", lat, 4);
        check("R4 reads", nrd, 2);
        check("R4 writes", nwr, 0);
        check("R4 value", value, 16'h1234);
        check("R4 err", err, 0);
        check("R4 mask", mask, 0);
    endtask

    task automatic t_read_vote(input logic [15:0] f0, input logic [15:0] f1,
                               input logic [15:0] f2, input logic [15:0] exp_val,
                               input logic exp_unres);
        int lat, nrd, nwr;
        rd_flip[0] = f0; rd_flip[1] = f1; rd_flip[2] = f2;
        run(1'b1, 12'h009, 16'h0000, lat, nrd, nwr);
        rd_flip[0] = '0; rd_flip[1] = '0; rd_flip[2] = '0;
        exp_cnt++;
        check("R5 latency", lat, 6);
        check("R5 reads", nrd, 3);
        check("R5 err", err, 1);
        check("R5 mask", mask, f0 ^ f1);
        check(exp_unres ? "R6 value" : "R5 value", value, exp_val);
        check("R6 unresolved", unres, exp_unres);
        check("R9 count", ecnt, exp_cnt);
    endtask

    task automatic t_hold();
        logic [15:0] m0, v0;
        m0 = mask; v0 = value;
        repeat (5) @(negedge clk);
        check("R7 done low", done, 0);
        check("R7 mask held", mask, m0);
        check("R7 value held", value, v0);
    endtask

    task automatic t_busy();
        int lat, rd0, wr0, dones;
        logic [15:0] before7;
        before7 = mem[7];
        @(negedge clk);
        rd0 = rd_total; wr0 = wr_total;
        req = 1'b1; req_mode = 1'b0; req_addr = 12'h003; req_data = 16'h00FF;
        @(negedge clk);
        req_addr = 12'h007; req_data = 16'hBEEF;
        @(negedge clk);
        req = 1'b0;
        dones = 0;
        for (int i = 0; i < 10; i++) begin
            if (done) dones++;
            @(negedge clk);
        end
        check("R8 done count", dones, 1);
        check("R8 addr", eaddr, 12'h003);
        check("R8 writes", wr_total - wr0, 1);
        check("R8 reads", rd_total - rd0, 1);
        check("R8 untouched", mem[7], before7);
    endtask

    task automatic t_counter();
        int lat, nrd, nwr;
        wr_flip = 16'h0001;
        for (int i = 0; i < 256; i++) run(1'b0, 12'h010, 16'h5555, lat, nrd, nwr);
        check("R9 saturated", ecnt, 255);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check("R10 cleared", ecnt, 0);
        // clear held across a failing verify: increment must lose
        @(negedge clk); clr = 1'b1;
        run(1'b0, 12'h011, 16'h7777, lat, nrd, nwr);
        @(negedge clk); clr = 1'b0;
        check("R10 clear priority", ecnt, 0);
        run(1'b0, 12'h011, 16'h7777, lat, nrd, nwr);
        check("R9 count after clear", ecnt, 1);
        wr_flip = 16'h0000;
    endtask

    initial begin
        rd_flip[0] = '0; rd_flip[1] = '0; rd_flip[2] = '0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_write_clean();
        t_write_fault();
        t_read_equal();
        t_read_vote(16'h0010, 16'h0000, 16'h0000, 16'h1234, 1'b0);
        t_read_vote(16'h0000, 16'h8000, 16'h0000, 16'h1234, 1'b0);
        t_read_vote(16'h0001, 16'h0002, 16'h0004, 16'h1236, 1'b1);
        t_hold();
        t_busy();
        t_counter();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule